// File: doc/BRIEF.md
# Synchronous Up/Down Counter with Split Count Inputs and Cascade Outputs

This block is a 4-bit binary counter whose direction is chosen by which of two count inputs pulses. A rising edge on `countUp`, while `countDown` rests high, adds one. A rising edge on `countDown`, while `countUp` rests high, subtracts one. Both count inputs pass through a two-stage synchronizer to the system clock. Rising edges are found on the synchronized copies. All state bits update together on one clock edge, so there is no ripple between them.

`clear` forces the count to zero and wins over everything else. `loadN` held low copies `data` into the count and wins over counting. The active-low `carryN` and `borrowN` outputs are level functions of the count and the synchronized count inputs. Each one stays low for as long as its count input is low at the top or bottom of the range. It therefore rises together with the count pulse that wraps the counter. Wider counters are built by feeding `carryN` into the next stage's `countUp` and `borrowN` into its `countDown`.

Top module: `updownCascadeCounter`

## Requirements
- R1: While `rstN` is low the count is 0. With both count inputs high, `carryN` and `borrowN` read 1 after reset.
- R2: A 0-to-1 change on `countUp`, with `countDown` high, raises the count by one. Each count input passes two synchronizer flops, so the new count appears after the third rising clock edge that follows the input change.
- R3: A 0-to-1 change on `countDown`, with `countUp` high, lowers the count by one, with the same three-edge latency.
- R4: The count holds if both synchronized count inputs rise in the same cycle. It also holds if one rises while the other synchronized input is low.
- R5: Counting wraps modulo 16: one up step from 15 gives 0, and one down step from 0 gives 15.
- R6: On any clock edge where `loadN` is low and `clear` is low, the count takes `data`, bit for bit (`data[i]` to `q[i]`), and any count edge seen in that cycle is dropped.
- R7: On any clock edge where `clear` is high, the count becomes 0, whatever `loadN`, `data` and the count inputs are.
- R8: `carryN` is 0 exactly when the synchronized `countUp` (the input delayed two clocks) is low and the count is 15. Otherwise it is 1.
- R9: `borrowN` is 0 exactly when the synchronized `countDown` is low and the count is 0. Otherwise it is 1.
- R10: Edge tracking continues while load or clear is active, so leaving load or clear never creates a count from levels already present.
- R11: Outside load and clear, the count moves by at most one step (mod 16) per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| countUp | input | 1 | Up-count pulse input, idle high |
| countDown | input | 1 | Down-count pulse input, idle high |
| loadN | input | 1 | Active-low parallel load |
| clear | input | 1 | Active-high clear, highest priority |
| data | input | 4 | Preset value |
| q | output | 4 | Counter value |
| carryN | output | 1 | Active-low overflow indication for cascading |
| borrowN | output | 1 | Active-low underflow indication for cascading |

## Verification
Two pairs of functions can fall in the same clock cycle. One pair is an up edge and a down edge. The other is a count edge and a load or clear. Directed sequences drop both count inputs and raise them together. They also raise a count input in the very cycle that load or clear is active, and then release the control so the bench can see that no late count appears. Random stimulus toggles the count inputs often and load and clear rarely, so these overlaps also occur by chance. Every cycle, the outputs are compared with a bench model that applies clear, then load, then the count rules to its own copy of the synchronizer delays.

// File: rtl/udcPkg.sv
package udcPkg;
  // strobes from the control to the datapath, one set per clock
  typedef struct packed {
    logic clr;        // force zero
    logic ld;         // take preset value
    logic inc;        // step up
    logic dec;        // step down
    logic upLevel;    // synchronized up-count level
    logic downLevel;  // synchronized down-count level
  } udcStrobes_t;
endpackage

// File: rtl/udcSync.sv
module udcSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] shiftReg;

  // idle level of a count input is high, so reset to ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '1;
    else       shiftReg <= {shiftReg[STAGES-2:0], din};
  end

  assign dout = shiftReg[STAGES-1];
endmodule

// File: rtl/udcCtrl.sv
module udcCtrl
  import udcPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        countUp,
  input  logic        countDown,
  input  logic        loadN,
  input  logic        clear,
  output udcStrobes_t strb
);
  localparam int NUM_INPUTS = 2;  // index 0 = up, 1 = down

  logic [NUM_INPUTS-1:0] rawIn;
  logic [NUM_INPUTS-1:0] syncd;
  logic [NUM_INPUTS-1:0] prevSyncd;
  logic [NUM_INPUTS-1:0] rise;
  logic                  countOk;

  assign rawIn = {countDown, countUp};

  for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_sync
    udcSync #(.STAGES(SYNC_STAGES)) uSync (
      .clk  (clk),
      .rstN (rstN),
      .din  (rawIn[i]),
      .dout (syncd[i])
    );
  end

  // history always follows the synchronized levels, even during load/clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevSyncd <= '1;
    else       prevSyncd <= syncd;
  end

  assign rise    = syncd & ~prevSyncd;
  assign countOk = loadN && !clear;

  always_comb begin
    strb           = '0;
    strb.clr       = clear;
    strb.ld        = !clear && !loadN;
    strb.inc       = countOk && rise[0] && !rise[1] && syncd[1];
    strb.dec       = countOk && rise[1] && !rise[0] && syncd[0];
    strb.upLevel   = syncd[0];
    strb.downLevel = syncd[1];
  end
endmodule

// File: rtl/udcDpath.sv
module udcDpath
  import udcPkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  udcStrobes_t      strb,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] q,
  output logic             carryN,
  output logic             borrowN
);
  localparam logic [WIDTH-1:0] MAX_VAL = '1;
  localparam logic [WIDTH-1:0] MIN_VAL = '0;

  logic [WIDTH-1:0] countReg;
  logic [WIDTH-1:0] countNext;

  always_comb begin
    countNext = countReg;
    if (strb.clr)      countNext = MIN_VAL;
    else if (strb.ld)  countNext = data;
    else if (strb.inc) countNext = countReg + 1'b1;
    else if (strb.dec) countNext = countReg - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) countReg <= MIN_VAL;
    else       countReg <= countNext;
  end

  assign q       = countReg;
  assign carryN  = !(!strb.upLevel   && countReg == MAX_VAL);
  assign borrowN = !(!strb.downLevel && countReg == MIN_VAL);
endmodule

// File: rtl/updownCascadeCounter.sv
module updownCascadeCounter
  import udcPkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countUp,
  input  logic             countDown,
  input  logic             loadN,
  input  logic             clear,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] q,
  output logic             carryN,
  output logic             borrowN
);
  udcStrobes_t strb;

  udcCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .countUp   (countUp),
    .countDown (countDown),
    .loadN     (loadN),
    .clear     (clear),
    .strb      (strb)
  );

  udcDpath #(.WIDTH(WIDTH)) uDpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .data    (data),
    .q       (q),
    .carryN  (carryN),
    .borrowN (borrowN)
  );
endmodule

// File: rtl/udcChecker.sv
module udcChecker #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             loadN,
  input logic             clear,
  input logic [WIDTH-1:0] data,
  input logic [WIDTH-1:0] q,
  input logic             carryN,
  input logic             borrowN
);
  // R7: clear forces zero on the next edge
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (q == '0));

  // R6: load copies the preset value
  p_load_copy_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && !loadN) |=> (q == $past(data)));

  // R11: at most one step per clock outside load/clear
  p_single_step_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && loadN) |=> (q == $past(q) || q == WIDTH'($past(q) + 1'b1)
                           || q == WIDTH'($past(q) - 1'b1)));

  // R8: carry only at the top of the range
  p_carry_top_r8: assert property (@(posedge clk) disable iff (!rstN)
    !carryN |-> (q == '1));

  // R9: borrow only at the bottom of the range
  p_borrow_bottom_r9: assert property (@(posedge clk) disable iff (!rstN)
    !borrowN |-> (q == '0));
endmodule

bind updownCascadeCounter udcChecker #(.WIDTH(WIDTH)) i_udcChecker (
  .clk     (clk),
  .rstN    (rstN),
  .loadN   (loadN),
  .clear   (clear),
  .data    (data),
  .q       (q),
  .carryN  (carryN),
  .borrowN (borrowN)
);

// File: tb/test_updownCascadeCounter.sv
module test_updownCascadeCounter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       countUp = 1'b1;
  logic       countDown = 1'b1;
  logic       loadN = 1'b1;
  logic       clear = 1'b0;
  logic [3:0] data = 4'd0;
  logic [3:0] q;
  logic       carryN;
  logic       borrowN;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // bench model state
  logic [3:0] mq = 4'd0;
  logic [1:0] mu = 2'b11, md = 2'b11;   // [0] first stage, [1] second stage
  logic       mup = 1'b1, mdp = 1'b1;
  string      qTag = "R1";

  always #5 clk = ~clk;

  updownCascadeCounter i_updownCascadeCounter (
    .clk(clk), .rstN(rstN), .countUp(countUp), .countDown(countDown),
    .loadN(loadN), .clear(clear), .data(data),
    .q(q), .carryN(carryN), .borrowN(borrowN)
  );

  function automatic logic expCarry(logic [3:0] c, logic upS);
    return !(!upS && c == 4'd15);
  endfunction

  function automatic logic expBorrow(logic [3:0] c, logic dnS);
    return !(!dnS && c == 4'd0);
  endfunction

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    logic ur, dr;
    ur = mu[1] & ~mup;
    dr = md[1] & ~mdp;
    if (clear) begin
      mq = 4'd0; qTag = "R7";
    end else if (!loadN) begin
      mq = data; qTag = "R6";
    end else if (ur && !dr && md[1]) begin
      qTag = (mq == 4'd15) ? "R5" : "R2"; mq = mq + 4'd1;
    end else if (dr && !ur && mu[1]) begin
      qTag = (mq == 4'd0) ? "R5" : "R3"; mq = mq - 4'd1;
    end else if (ur || dr) begin
      qTag = "R4";
    end else begin
      qTag = "R10";
    end
    mup = mu[1]; mdp = md[1];
    mu = {mu[0], countUp};
    md = {md[0], countDown};
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(logic cu, logic cd, logic ld, logic cl, logic [3:0] dt);
    countUp = cu; countDown = cd; loadN = ld; clear = cl; data = dt;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check(qTag, q, mq);
    check("R8 carryN", carryN, expCarry(mq, mu[1]));
    check("R9 borrowN", borrowN, expBorrow(mq, md[1]));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 1, 0, 4'd0);
  endtask

  task automatic pulseUp();
    cyc(0, 1, 1, 0, 4'd0); cyc(0, 1, 1, 0, 4'd0); idle(4);
  endtask

  task automatic pulseDown();
    cyc(1, 0, 1, 0, 4'd0); cyc(1, 0, 1, 0, 4'd0); idle(4);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset q", q, 0);
    check("R1 reset carryN", carryN, 1);
    check("R1 reset borrowN", borrowN, 1);
    rstN = 1'b1;
    idle(3);

    // R2: up steps
    pulseUp(); pulseUp();
    // R3: down step
    pulseDown();
    // R5: wrap up from 15
    cyc(1, 1, 0, 0, 4'd15); idle(3);
    pulseUp();
    // R5: wrap down from 0
    pulseDown();
    // R4: both rise together
    cyc(0, 0, 1, 0, 4'd0); cyc(0, 0, 1, 0, 4'd0); idle(4);
    // R4: up rises while down low
    cyc(1, 0, 1, 0, 4'd0); cyc(0, 0, 1, 0, 4'd0); cyc(0, 0, 1, 0, 4'd0);
    cyc(1, 0, 1, 0, 4'd0); cyc(1, 0, 1, 0, 4'd0); cyc(1, 0, 1, 0, 4'd0);
    idle(4);
    // R6/R10: edge lands during load, then load released
    cyc(0, 1, 1, 0, 4'd0); cyc(0, 1, 1, 0, 4'd0);
    cyc(1, 1, 0, 0, 4'd9); cyc(1, 1, 0, 0, 4'd9); cyc(1, 1, 0, 0, 4'd9);
    idle(4);
    // R7/R10: clear beats load and a down edge
    cyc(1, 0, 1, 0, 4'd0); cyc(1, 0, 1, 0, 4'd0);
    cyc(1, 1, 0, 1, 4'd5); cyc(1, 1, 0, 1, 4'd5); cyc(1, 1, 0, 1, 4'd5);
    idle(4);

    // constrained random mix
    begin
      logic cu, cd;
      cu = 1; cd = 1;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom_range(0, 2) == 0) cu = ~cu;
        if ($urandom_range(0, 2) == 0) cd = ~cd;
        cyc(cu, cd, ($urandom_range(0, 15) != 0), ($urandom_range(0, 31) == 0),
            4'($urandom_range(0, 15)));
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule